// File: doc/BRIEF.md
# Packed-instruction operand half selector

This block sits between instruction fetch and a two-lane 16-bit ALU. It takes one 64-bit packed-math instruction word together with the three 32-bit source values already read for it. It pulls out the destination index, the opcode, the saturate flag and the three source identifiers. It also checks that the fixed signature field marks the word as a packed-math instruction.

For every source, two select bits decide which 16-bit half of that source feeds the low lane and which half feeds the high lane. The high-lane select bits are not contiguous in the word. When the opcode is a floating-point one, two separate 3-bit negate masks, one for each lane, flip the sign bit of the chosen halves. Integer opcodes pass the halves through unchanged.

All outputs are registered with one cycle of latency. A word whose signature does not match raises `illegal` rather than `valid_out`. The lane ALU consumes the operands only when `valid_out` is high.

Top module: `pk_operand_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero. Reset is synchronous and active-low.
- R2: When `valid_in` is high and instruction bits 31:23 equal 9'b110100111, `valid_out` is high and `illegal` is low on the next cycle.
- R3: When `valid_in` is high and bits 31:23 differ from 9'b110100111, `illegal` is high and `valid_out` is low on the next cycle.
- R4: The fields are taken from fixed positions and presented one cycle later: `dst` from bits 7:0, `opcode` from bits 22:16, `clamp` from bit 15, and `src_ids` slots 0, 1 and 2 from bits 40:32, 49:41 and 58:50.
- R5: The low-lane operand of source i (i = 0, 1, 2) is taken from `lo_ops[16i+15:16i]`. Its select bit is instruction bit 11+i. A value of 0 picks bits 15:0 of source i and a value of 1 picks bits 31:16.
- R6: The high-lane operand of source i is taken from `hi_ops[16i+15:16i]`. Its select bit is bit 14 for source 0, bit 59 for source 1 and bit 60 for source 2, with the same 0/1 meaning as in R5.
- R7: Opcodes 14 to 18 and 32 to 34 are floating-point. For these, `float_op` is 1. Bit 61+i set inverts bit 15 of the low-lane operand of source i, and bit 8+i set inverts bit 15 of the high-lane operand of source i. No other operand bit changes.
- R8: Every other opcode is integer. For these, `float_op` is 0, both negate masks are ignored, and the operands are the selected halves unchanged.
- R9: A cycle with `valid_in` low gives `valid_out` and `illegal` low on the next cycle. All data outputs keep their previous values.
- R10: Instructions presented on consecutive cycles each produce their own result exactly one cycle later, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Instruction word and source values are present |
| instr | input | 64 | Packed-math instruction word |
| src_data | input | 96 | Source i value in bits 32i+31:32i |
| valid_out | output | 1 | Registered operands belong to a well-formed instruction |
| illegal | output | 1 | Registered instruction failed the signature check |
| dst | output | 8 | Destination index |
| opcode | output | 7 | Operation code |
| clamp | output | 1 | Saturate flag |
| float_op | output | 1 | Opcode is of the floating-point class |
| src_ids | output | 27 | Source identifier i in bits 9i+8:9i |
| lo_ops | output | 48 | Low-lane operand of source i in bits 16i+15:16i |
| hi_ops | output | 48 | High-lane operand of source i in bits 16i+15:16i |

## Verification
Half selection and sign negation can act on the same operand in the same cycle. Both lanes of one source can also read the same half while different negate bits are applied to each lane. The bench provokes this by sweeping all 64 combinations of the six select bits against all 64 combinations of the two negate masks. The sweep is repeated for floating-point opcodes and for integer opcodes, including the opcodes at the edges of the floating-point ranges. Each lane operand is compared with a value computed from the half-pick rule and the bit-15 inversion rule, so any interaction between selection and negation shows up as a mismatch.

// File: rtl/pk_route_pkg.sv
// Package: shared widths, instruction field positions and decoded-field type
// for the packed-instruction operand half selector.
// Assumes a 64-bit instruction word carrying three 32-bit sources, each split
// into two 16-bit halves. Field positions are fixed by the instruction format.
package pk_route_pkg;

    localparam int SRC_N    = 3;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int INSTR_W  = 64;
    localparam int DST_W    = 8;
    localparam int OPC_W    = 7;
    localparam int SRC_ID_W = 9;
    localparam int SIG_W    = 9;

    localparam int SRC_BUS_W = SRC_N * WORD_W;
    localparam int OPS_W     = SRC_N * HALF_W;
    localparam int IDS_W     = SRC_N * SRC_ID_W;

    // Bit positions inside the instruction word
    localparam int DST_LSB    = 0;
    localparam int NEG_HI_LSB = 8;
    localparam int SEL_LO_LSB = 11;
    localparam int CLAMP_POS  = 15;
    localparam int OPC_LSB    = 16;
    localparam int SIG_LSB    = 23;
    localparam int SRCID_LSB  = 32;
    localparam int NEG_LO_LSB = 61;

    localparam logic [SIG_W-1:0] SIG_VALUE = 9'b110100111;

    // Opcode bounds of the floating-point class
    localparam logic [OPC_W-1:0] FP_A_FIRST = 7'd14;
    localparam logic [OPC_W-1:0] FP_A_LAST  = 7'd18;
    localparam logic [OPC_W-1:0] FP_B_FIRST = 7'd32;
    localparam logic [OPC_W-1:0] FP_B_LAST  = 7'd34;

    // High-lane select bit of source i: source 0 sits below the clamp bit,
    // sources 1 and 2 sit just above the third source field.
    function automatic int sel_hi_pos(input int idx);
        return (idx == 0) ? 14 : (58 + idx);
    endfunction

    // True when the opcode belongs to the floating-point class
    function automatic logic opc_is_float(input logic [OPC_W-1:0] opc);
        return ((opc >= FP_A_FIRST) && (opc <= FP_A_LAST)) ||
               ((opc >= FP_B_FIRST) && (opc <= FP_B_LAST));
    endfunction

    typedef struct packed {
        logic [DST_W-1:0]               dst;
        logic [OPC_W-1:0]               opc;
        logic                           clamp;
        logic                           is_float;
        logic                           sig_ok;
        logic [SRC_N-1:0][SRC_ID_W-1:0] src_id;
        logic [SRC_N-1:0]               sel_lo;
        logic [SRC_N-1:0]               sel_hi;
        logic [SRC_N-1:0]               neg_lo;
        logic [SRC_N-1:0]               neg_hi;
    } pk_fields_t;

endpackage

// File: rtl/pk_instr_decode.sv
// Module: pk_instr_decode
// Splits a packed-math instruction word into its fields, gathers the scattered
// high-lane select bits, classifies the opcode and checks the signature.
// Purely combinational; assumes the word is stable while it is sampled.
module pk_instr_decode
    import pk_route_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output pk_fields_t         fields
);

    // Field extraction and per-source bit gathering
    always_comb begin
        fields          = '0;
        fields.dst      = instr[DST_LSB +: DST_W];
        fields.opc      = instr[OPC_LSB +: OPC_W];
        fields.clamp    = instr[CLAMP_POS];
        fields.sig_ok   = (instr[SIG_LSB +: SIG_W] == SIG_VALUE);
        fields.is_float = opc_is_float(instr[OPC_LSB +: OPC_W]);
        for (int i = 0; i < SRC_N; i++) begin
            fields.src_id[i] = instr[SRCID_LSB + i*SRC_ID_W +: SRC_ID_W];
            fields.sel_lo[i] = instr[SEL_LO_LSB + i];
            fields.sel_hi[i] = instr[sel_hi_pos(i)];
            fields.neg_lo[i] = instr[NEG_LO_LSB + i];
            fields.neg_hi[i] = instr[NEG_HI_LSB + i];
        end
    end

endmodule

// File: rtl/pk_half_select.sv
// Module: pk_half_select
// For one source word, picks the half for each lane and applies that lane's
// sign inversion when the opcode is floating-point. Combinational.
// Assumes the sign of a half-width value sits in its top bit.
module pk_half_select #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word,
    input  logic                sel_lo,
    input  logic                sel_hi,
    input  logic                neg_lo,
    input  logic                neg_hi,
    input  logic                is_float,
    output logic [HALF_W-1:0]   lo_op,
    output logic [HALF_W-1:0]   hi_op
);

    localparam logic [HALF_W-1:0] SIGN_MASK = {1'b1, {(HALF_W-1){1'b0}}};

    logic [HALF_W-1:0] lo_half;
    logic [HALF_W-1:0] hi_half;
    logic [HALF_W-1:0] lo_flip;
    logic [HALF_W-1:0] hi_flip;

    // Half choice per lane: 0 picks the lower half, 1 the upper half
    always_comb begin
        lo_half = sel_lo ? word[HALF_W +: HALF_W] : word[0 +: HALF_W];
        hi_half = sel_hi ? word[HALF_W +: HALF_W] : word[0 +: HALF_W];
    end

    // Sign inversion masks, active only for floating-point opcodes
    always_comb begin
        lo_flip = (is_float && neg_lo) ? SIGN_MASK : '0;
        hi_flip = (is_float && neg_hi) ? SIGN_MASK : '0;
    end

    // Final lane operands
    always_comb begin
        lo_op = lo_half ^ lo_flip;
        hi_op = hi_half ^ hi_flip;
    end

endmodule

// File: rtl/pk_operand_router.sv
// Module: pk_operand_router (top)
// Decodes a packed-math instruction, routes the three source values into
// low-lane and high-lane 16-bit operands, and registers everything with one
// cycle of latency. A failed signature check raises illegal, not valid_out.
// Assumes src_data is aligned with instr in the cycle valid_in is high.
// Data outputs hold their value in cycles without valid_in.
module pk_operand_router
    import pk_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [SRC_BUS_W-1:0] src_data,
    output logic                 valid_out,
    output logic                 illegal,
    output logic [DST_W-1:0]     dst,
    output logic [OPC_W-1:0]     opcode,
    output logic                 clamp,
    output logic                 float_op,
    output logic [IDS_W-1:0]     src_ids,
    output logic [OPS_W-1:0]     lo_ops,
    output logic [OPS_W-1:0]     hi_ops
);

    pk_fields_t         fields;
    logic [OPS_W-1:0]   lo_next;
    logic [OPS_W-1:0]   hi_next;
    logic [IDS_W-1:0]   ids_next;

    pk_instr_decode u_decode (
        .instr  (instr),
        .fields (fields)
    );

    // One selector per source
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        pk_half_select #(.HALF_W(HALF_W)) u_sel (
            .word     (src_data[g*WORD_W +: WORD_W]),
            .sel_lo   (fields.sel_lo[g]),
            .sel_hi   (fields.sel_hi[g]),
            .neg_lo   (fields.neg_lo[g]),
            .neg_hi   (fields.neg_hi[g]),
            .is_float (fields.is_float),
            .lo_op    (lo_next[g*HALF_W +: HALF_W]),
            .hi_op    (hi_next[g*HALF_W +: HALF_W])
        );
        assign ids_next[g*SRC_ID_W +: SRC_ID_W] = fields.src_id[g];
    end

    // Status register: valid or illegal for each presented word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            valid_out <= valid_in &&  fields.sig_ok;
            illegal   <= valid_in && !fields.sig_ok;
        end
    end

    // Data register: loads on valid_in, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst      <= '0;
            opcode   <= '0;
            clamp    <= 1'b0;
            float_op <= 1'b0;
            src_ids  <= '0;
            lo_ops   <= '0;
            hi_ops   <= '0;
        end else if (valid_in) begin
            dst      <= fields.dst;
            opcode   <= fields.opc;
            clamp    <= fields.clamp;
            float_op <= fields.is_float;
            src_ids  <= ids_next;
            lo_ops   <= lo_next;
            hi_ops   <= hi_next;
        end
    end

endmodule

// File: rtl/pk_operand_router_chk.sv
// Module: pk_operand_router_chk
// Property checker bound to pk_operand_router. It relates registered outputs
// to the inputs of the previous cycle. Assumes valid_in is low during reset.
module pk_operand_router_chk
    import pk_route_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 valid_in,
    input logic [INSTR_W-1:0]   instr,
    input logic [SRC_BUS_W-1:0] src_data,
    input logic                 valid_out,
    input logic                 illegal,
    input logic                 float_op,
    input logic [DST_W-1:0]     dst,
    input logic [OPS_W-1:0]     lo_ops,
    input logic [OPS_W-1:0]     hi_ops
);

    a_r2_valid_has_signature: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> ($past(valid_in) && ($past(instr[SIG_LSB +: SIG_W]) == SIG_VALUE)));

    a_r3_illegal_has_bad_signature: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($past(valid_in) && ($past(instr[SIG_LSB +: SIG_W]) != SIG_VALUE) && !valid_out));

    a_r9_idle_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!valid_out && !illegal));

    a_r9_idle_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(lo_ops) && $stable(hi_ops) && $stable(dst)));

    a_r8_int_low_src0_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !float_op) |->
            (lo_ops[HALF_W-1:0] == ($past(instr[SEL_LO_LSB]) ?
                $past(src_data[WORD_W-1:HALF_W]) : $past(src_data[HALF_W-1:0]))));

    a_r6_int_high_src1_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !float_op) |->
            (hi_ops[2*HALF_W-1:HALF_W] == ($past(instr[sel_hi_pos(1)]) ?
                $past(src_data[2*WORD_W-1:WORD_W+HALF_W]) : $past(src_data[WORD_W+HALF_W-1:WORD_W]))));

    a_r7_float_low_body_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && float_op) |->
            (lo_ops[HALF_W-2:0] == ($past(instr[SEL_LO_LSB]) ?
                $past(src_data[WORD_W-2:HALF_W]) : $past(src_data[HALF_W-2:0]))));

endmodule

bind pk_operand_router pk_operand_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .instr     (instr),
    .src_data  (src_data),
    .valid_out (valid_out),
    .illegal   (illegal),
    .float_op  (float_op),
    .dst       (dst),
    .lo_ops    (lo_ops),
    .hi_ops    (hi_ops)
);

// File: tb/pk_operand_router_tb.sv
// Bench for pk_operand_router: reset state, field extraction, signature
// handling, idle hold, back-to-back issue, and an exhaustive sweep of select
// bits against negate masks over floating-point and integer opcodes.
module pk_operand_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [63:0] instr = '0;
    logic [95:0] src_data = '0;
    logic        valid_out, illegal, clamp, float_op;
    logic [7:0]  dst;
    logic [6:0]  opcode;
    logic [26:0] src_ids;
    logic [47:0] lo_ops, hi_ops;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [8:0] SIG = 9'b110100111;

    always #2.5 clk = ~clk;   // 200 MHz

    pk_operand_router u_dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .instr(instr),
        .src_data(src_data), .valid_out(valid_out), .illegal(illegal),
        .dst(dst), .opcode(opcode), .clamp(clamp), .float_op(float_op),
        .src_ids(src_ids), .lo_ops(lo_ops), .hi_ops(hi_ops)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] make_instr(
        input logic [8:0] sig, input logic [6:0] opc, input logic [7:0] d,
        input logic cl, input logic [2:0] sello, input logic [2:0] selhi,
        input logic [2:0] neglo, input logic [2:0] neghi,
        input logic [8:0] id0, input logic [8:0] id1, input logic [8:0] id2);
        logic [63:0] w;
        w = '0;
        w[7:0]   = d;
        w[10:8]  = neghi;
        w[13:11] = sello;
        w[14]    = selhi[0];
        w[15]    = cl;
        w[22:16] = opc;
        w[31:23] = sig;
        w[40:32] = id0;
        w[49:41] = id1;
        w[58:50] = id2;
        w[59]    = selhi[1];
        w[60]    = selhi[2];
        w[63:61] = neglo;
        return w;
    endfunction

    function automatic logic is_fp(input logic [6:0] o);
        return (o >= 7'd14 && o <= 7'd18) || (o >= 7'd32 && o <= 7'd34);
    endfunction

    // Expected operand: chosen half, sign flipped for a negated float operand
    function automatic logic [15:0] exp_half(input logic [31:0] w, input logic sel,
                                             input logic neg, input logic fp);
        logic [15:0] h;
        h = sel ? w[31:16] : w[15:0];
        if (fp && neg) h = {~h[15], h[14:0]};
        return h;
    endfunction

    function automatic logic [31:0] mk_word(input int k, input int i);
        return 32'(32'h9E3779B9 * (k * 3 + i + 1)) ^ 32'(k << 7);
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        logic [47:0] prev_lo;
        logic [6:0]  opc_list [8];
        int k;
        opc_list = '{7'd0, 7'd13, 7'd14, 7'd18, 7'd19, 7'd32, 7'd34, 7'd35};

        // R1: reset clears outputs
        instr    = make_instr(SIG, 7'd15, 8'hFF, 1'b1, 3'b111, 3'b111, 3'b111, 3'b111, 9'h1FF, 9'h1FF, 9'h1FF);
        src_data = {96{1'b1}};
        repeat (3) @(negedge clk);
        check("R1 valid_out", {63'b0, valid_out}, 64'd0);
        check("R1 illegal",   {63'b0, illegal},   64'd0);
        check("R1 lo_ops",    {16'b0, lo_ops},    64'd0);
        check("R1 hi_ops",    {16'b0, hi_ops},    64'd0);
        check("R1 dst/opc/ids", {28'b0, dst, opcode, clamp, float_op, src_ids}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4, R2: field extraction for a few distinct words
        for (int t = 0; t < 4; t++) begin
            logic [8:0] a, b, c;
            a = 9'(37 * t + 5); b = 9'(511 - 61 * t); c = 9'(128 + 97 * t);
            valid_in = 1'b1;
            instr = make_instr(SIG, 7'(t * 29 + 3), 8'(t * 71 + 9), t[0],
                               3'(t), 3'(t + 1), 3'(t + 2), 3'(t + 3), a, b, c);
            src_data = {mk_word(t, 2), mk_word(t, 1), mk_word(t, 0)};
            @(negedge clk);
            check("R2 valid_out", {63'b0, valid_out}, 64'd1);
            check("R2 illegal",   {63'b0, illegal},   64'd0);
            check("R4 dst",    {56'b0, dst},     {56'b0, 8'(t * 71 + 9)});
            check("R4 opcode", {57'b0, opcode},  {57'b0, 7'(t * 29 + 3)});
            check("R4 clamp",  {63'b0, clamp},   {63'b0, t[0]});
            check("R4 src_ids", {37'b0, src_ids}, {37'b0, c, b, a});
        end

        // R3: bad signatures raise illegal
        begin
            logic [8:0] bad [3];
            bad = '{9'b110100110, 9'h000, 9'h1FF};
            for (int t = 0; t < 3; t++) begin
                instr = make_instr(bad[t], 7'd14, 8'h11, 1'b0, 3'b0, 3'b0, 3'b0, 3'b0, 9'd1, 9'd2, 9'd3);
                @(negedge clk);
                check("R3 illegal",   {63'b0, illegal},   64'd1);
                check("R3 valid_out", {63'b0, valid_out}, 64'd0);
            end
        end

        // R9: idle cycle holds data and drops status
        instr = make_instr(SIG, 7'd2, 8'h5A, 1'b0, 3'b101, 3'b010, 3'b0, 3'b0, 9'd4, 9'd5, 9'd6);
        src_data = {mk_word(9, 2), mk_word(9, 1), mk_word(9, 0)};
        @(negedge clk);
        prev_lo = lo_ops;
        valid_in = 1'b0;
        instr = make_instr(SIG, 7'd16, 8'hA5, 1'b1, 3'b010, 3'b101, 3'b111, 3'b111, 9'd7, 9'd8, 9'd9);
        src_data = ~src_data;
        @(negedge clk);
        check("R9 valid_out idle", {63'b0, valid_out}, 64'd0);
        check("R9 illegal idle",   {63'b0, illegal},   64'd0);
        check("R9 lo_ops held",    {16'b0, lo_ops},    {16'b0, prev_lo});
        check("R9 dst held",       {56'b0, dst},       {56'b0, 8'h5A});

        // R10: alternating good and bad words on consecutive cycles
        valid_in = 1'b1;
        for (int t = 0; t < 8; t++) begin
            instr = make_instr(t[0] ? 9'h0F0 : SIG, 7'd10, 8'(t), 1'b0, 3'(t), 3'(7 - t), 3'b0, 3'b0, 9'd0, 9'd0, 9'd0);
            src_data = {mk_word(t + 20, 2), mk_word(t + 20, 1), mk_word(t + 20, 0)};
            @(negedge clk);
            check("R10 valid_out", {63'b0, valid_out}, {63'b0, ~t[0]});
            check("R10 illegal",   {63'b0, illegal},   {63'b0, t[0]});
            check("R10 dst",       {56'b0, dst},       {56'b0, 8'(t)});
        end

        // R5, R6, R7, R8: selects x negate masks x opcode classes
        k = 0;
        for (int o = 0; o < 8; o++) begin
            for (int s = 0; s < 64; s++) begin
                for (int n = 0; n < 64; n++) begin
                    logic [47:0] elo, ehi;
                    logic [31:0] sw [3];
                    logic fp;
                    logic [2:0] slo, shi, nlo, nhi;
                    slo = 3'(s); shi = 3'(s >> 3); nlo = 3'(n); nhi = 3'(n >> 3);
                    fp = is_fp(opc_list[o]);
                    for (int i = 0; i < 3; i++) sw[i] = mk_word(k, i);
                    for (int i = 0; i < 3; i++) begin
                        elo[16*i +: 16] = exp_half(sw[i], slo[i], nlo[i], fp);
                        ehi[16*i +: 16] = exp_half(sw[i], shi[i], nhi[i], fp);
                    end
                    instr = make_instr(SIG, opc_list[o], 8'(k), 1'b0, slo, shi, nlo, nhi, 9'd0, 9'd0, 9'd0);
                    src_data = {sw[2], sw[1], sw[0]};
                    @(negedge clk);
                    if (fp) begin
                        check("R7 lo_ops float", {16'b0, lo_ops}, {16'b0, elo});
                        check("R7 hi_ops float", {16'b0, hi_ops}, {16'b0, ehi});
                    end else begin
                        check("R5 R8 lo_ops int", {16'b0, lo_ops}, {16'b0, elo});
                        check("R6 R8 hi_ops int", {16'b0, hi_ops}, {16'b0, ehi});
                    end
                    if (n == 0 && s == 0)
                        check("R7 R8 float_op", {63'b0, float_op}, {63'b0, fp});
                    k++;
                end
            end
        end
        valid_in = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule